// File: doc/BRIEF.md
# Eight-Bit Timer Waveform Generator

This block is an 8-bit counter with two compare channels, A and B. It produces two waveform pins from them. A count-enable input advances the counter by one step per enabled clock cycle. A 3-bit mode code sets the counting sequence and the TOP value, and TOP is either 0xFF or the active compare A value. The supported sequences are free-running, clear on compare match, single-slope PWM and dual-slope (up/down) PWM. Each channel has a 2-bit output-action field that tells the pin what to do on a compare match, and at TOP or BOTTOM in the PWM modes.

The counter and both compare registers are loaded through a single write port. Everything is read back through a combinational read port. In the non-PWM modes a compare value takes effect as soon as it is written. In the PWM modes a write goes to a holding register, and the value moves to the active register at a point that depends on the mode. Three event flags (overflow, match A, match B) each have an enable bit. Together they drive one interrupt request. A flag is cleared by writing a one to it or by pulsing its acknowledge line. A force strobe lets software apply a channel's output action directly in the non-PWM modes.

Register map (address: content): 0 configuration, 1 counter, 2 compare A, 3 compare B, 4 interrupt enables, 5 flags, 6 force strobe. The configuration byte holds the mode in bits [2:0], the channel A action in [5:4] and the channel B action in [7:6]. In registers 4, 5 and 6 and in the acknowledge input, bit 0 is overflow, bit 1 is channel A and bit 2 is channel B. The force register uses only bit 0 (A) and bit 1 (B).

Top module: `timer8_wavegen`

## Requirements
- R1: After reset every register reads zero, both waveform pins, both override outputs and the interrupt request are low, and the count direction is up.
- R2: The counting sequence is set by the mode code. Modes 0 and the reserved 4 and 6 count up and wrap from 0xFF to 0. Mode 2 and the single-slope modes 3 and 7 return to 0 on the step taken at TOP. The dual-slope modes 1 and 5 count up to TOP, then down to 0, then up again. TOP is compare A in modes 2, 5 and 7 and 0xFF otherwise.
- R3: The overflow flag (bit 0) is set on a step taken at 0xFF in modes 0, 2, 3, 4 and 6. It is set on the step taken at TOP in mode 7. In modes 1 and 5 it is set on the step where the count turns from down to up at 0.
- R4: A step taken while the count equals a channel's active compare value sets that channel's flag (A bit 1, B bit 2). The first step after a counter write produces no compare match.
- R5: In the non-PWM modes (0, 2, 4, 6), action code 01 toggles the pin on a match, 10 clears it, 11 sets it and 00 leaves it unchanged.
- R6: A one written to force bit 0 or 1 applies that channel's action once, and only in a non-PWM mode. It sets no flag, leaves the counter unchanged, and address 6 always reads back 0.
- R7: In modes 3 and 7, code 10 clears the pin on a match and sets it on the step at TOP, and code 11 does the opposite. On the step at TOP the TOP action wins over a match, so a compare value equal to TOP gives a constant pin.
- R8: In modes 1 and 5, code 10 clears the pin on a match while counting up and sets it on a match while counting down, and code 11 does the opposite. At a turning point the action of the direction being entered applies.
- R9: In a PWM mode, code 01 on channel A toggles the pin on a match only when mode bit 2 is 1. Code 01 on channel B never changes the pin.
- R10: The active compare values, read at addresses 2 and 3, follow writes at once in the non-PWM modes. In modes 1 and 5 they load on the step at TOP while counting up. In modes 3 and 7 they load on the step at TOP that returns the count to 0.
- R11: A flag bit clears when a one is written to it at address 5 or its acknowledge bit is pulsed. The interrupt request is high exactly when some flag and its enable are both set.
- R12: A channel's override output is high whenever its action field is non-zero.
- R13: Addresses 0 and 4 read back the last value written, and address 1 reads the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count enable; one counter step per enabled cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| intAck | input | 3 | Per-flag acknowledge pulses that clear flags |
| wavA | output | 1 | Channel A waveform pin |
| wavB | output | 1 | Channel B waveform pin |
| ovrA | output | 1 | Channel A pin override |
| ovrB | output | 1 | Channel B pin override |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or direction shows up at the read port on the next step. In the dual-slope modes it also shows in the wrong pin action one or two steps later, because the action taken on a match depends on the direction. A wrong update point for the holding registers appears as a stale or early value at addresses 2 and 3, seen on the step at TOP. A stuck write-block or a forced compare that leaks into the flags shows in the flag register and the interrupt line in the cycle after the stimulus. The single-slope constant-pin case exposes a wrong priority only on the step at TOP, so the checks are sampled right after that step.

// File: rtl/timer8_pkg.sv
package timer8_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 3;
  localparam int FLAG_N = 3;
  localparam int CH_N   = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_FORCE = 3'd6;

  localparam int FLG_OVF = 0;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {STEP_HOLD, STEP_INC, STEP_DEC, STEP_CLR} step_e;

  typedef struct packed {
    step_e step;
    logic  goDown;
    logic  goUp;
    logic  loadCmp;
    logic  immUpd;
  } dpCtl_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             down;
    logic [CNT_W-1:0] cmpA;
    logic [CNT_W-1:0] cmpB;
    logic             blocked;
  } dpStat_t;
endpackage

// File: rtl/timer8_datapath.sv
module timer8_datapath
  import timer8_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   cntWr,
  input  logic [CH_N-1:0]        cmpWr,
  input  logic [CNT_W-1:0]       wrData,
  input  dpCtl_t                 ctl,
  output dpStat_t                stat
);
  logic [CNT_W-1:0] cntR;
  logic             downR;
  logic             blockR;
  logic [CNT_W-1:0] actR [CH_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntR   <= '0;
      downR  <= 1'b0;
      blockR <= 1'b0;
    end else begin
      if (cntWr) begin
        cntR   <= wrData;
        blockR <= 1'b1;
      end else begin
        unique case (ctl.step)
          STEP_INC: cntR <= cntR + 1'b1;
          STEP_DEC: cntR <= cntR - 1'b1;
          STEP_CLR: cntR <= '0;
          default:  cntR <= cntR;
        endcase
        if (tick) blockR <= 1'b0;
      end
      if (ctl.goDown)    downR <= 1'b1;
      else if (ctl.goUp) downR <= 1'b0;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_cmp
    logic [CNT_W-1:0] bufR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufR    <= '0;
        actR[i] <= '0;
      end else begin
        if (cmpWr[i]) bufR <= wrData;
        if (cmpWr[i] && ctl.immUpd) actR[i] <= wrData;
        else if (ctl.loadCmp)       actR[i] <= bufR;
      end
    end
  end

  always_comb begin
    stat.cnt     = cntR;
    stat.down    = downR;
    stat.cmpA    = actR[0];
    stat.cmpB    = actR[1];
    stat.blocked = blockR;
  end
endmodule

// File: rtl/timer8_control.sv
module timer8_control
  import timer8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cfgWr,
  input  logic              ienWr,
  input  logic              flagWr,
  input  logic              forceWr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [FLAG_N-1:0] intAck,
  input  dpStat_t           stat,
  output dpCtl_t            ctl,
  output logic [CNT_W-1:0]  cfg,
  output logic [FLAG_N-1:0] ien,
  output logic [FLAG_N-1:0] flags,
  output logic [CH_N-1:0]   wav,
  output logic [CH_N-1:0]   ovr,
  output logic              irq
);
  logic [CNT_W-1:0]  cfgR;
  logic [FLAG_N-1:0] ienR, flagR;
  logic [CH_N-1:0]   wavR;

  logic [2:0] mode;
  logic [1:0] code [CH_N];
  logic isPhase, isFast, isCtc, isPwm, topIsA;
  logic [CNT_W-1:0] topVal;
  logic atTop, atZero, atMax, turnDown, ovfSet;
  logic [CH_N-1:0] match, forced;
  logic [CNT_W-1:0] cmpVal [CH_N];

  assign mode    = cfgR[2:0];
  assign code[0] = cfgR[5:4];
  assign code[1] = cfgR[7:6];
  assign cmpVal[0] = stat.cmpA;
  assign cmpVal[1] = stat.cmpB;

  assign isPhase = (mode == 3'd1) || (mode == 3'd5);
  assign isFast  = (mode == 3'd3) || (mode == 3'd7);
  assign isCtc   = (mode == 3'd2);
  assign isPwm   = isPhase || isFast;
  assign topIsA  = isCtc || (mode == 3'd5) || (mode == 3'd7);
  assign topVal  = topIsA ? stat.cmpA : CNT_MAX;
  assign atTop   = (stat.cnt == topVal);
  assign atZero  = (stat.cnt == '0);
  assign atMax   = (stat.cnt == CNT_MAX);
  // direction whose action applies at this step: the one being entered at a turn
  assign turnDown = stat.down ? !atZero : atTop;

  always_comb begin
    ctl = '0;
    ctl.immUpd = !isPwm;
    if (tick) begin
      if (isPhase) begin
        if (!stat.down) begin
          if (atTop) begin
            ctl.goDown  = 1'b1;
            ctl.step    = atZero ? STEP_HOLD : STEP_DEC;
            ctl.loadCmp = 1'b1;
          end else ctl.step = STEP_INC;
        end else begin
          if (atZero) begin
            ctl.goUp = 1'b1;
            ctl.step = atTop ? STEP_HOLD : STEP_INC;
          end else ctl.step = STEP_DEC;
        end
      end else if (isFast || isCtc) begin
        ctl.step    = atTop ? STEP_CLR : STEP_INC;
        ctl.loadCmp = isFast && atTop;
      end else begin
        ctl.step = STEP_INC;
      end
    end
  end

  assign ovfSet = tick && (isFast ? atTop : (isPhase ? (stat.down && atZero) : atMax));

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic nxt;
    assign match[i]  = tick && !stat.blocked && (stat.cnt == cmpVal[i]);
    assign forced[i] = forceWr && wrData[i] && !isPwm;
    assign ovr[i]    = (code[i] != 2'b00);

    always_comb begin
      nxt = wavR[i];
      if (!isPwm) begin
        if (match[i] || forced[i]) begin
          unique case (code[i])
            2'b01:   nxt = ~wavR[i];
            2'b10:   nxt = 1'b0;
            2'b11:   nxt = 1'b1;
            default: nxt = wavR[i];
          endcase
        end
      end else if (code[i] == 2'b01) begin
        if ((i == 0) && mode[2] && match[i]) nxt = ~wavR[i];
      end else if (code[i][1]) begin
        if (isFast) begin
          if (tick && atTop)  nxt = ~code[i][0];
          else if (match[i])  nxt = code[i][0];
        end else if (match[i]) begin
          nxt = turnDown ? ~code[i][0] : code[i][0];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) wavR[i] <= 1'b0;
      else       wavR[i] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgR  <= '0;
      ienR  <= '0;
      flagR <= '0;
    end else begin
      if (cfgWr) cfgR <= wrData;
      if (ienWr) ienR <= wrData[FLAG_N-1:0];
      flagR <= (flagR & ~(intAck | (flagWr ? wrData[FLAG_N-1:0] : '0)))
             | {match[1], match[0], ovfSet};
    end
  end

  assign cfg   = cfgR;
  assign ien   = ienR;
  assign flags = flagR;
  assign wav   = wavR;
  assign irq   = |(flagR & ienR);
endmodule

// File: rtl/timer8_wavegen.sv
module timer8_wavegen
  import timer8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic [FLAG_N-1:0] intAck,
  output logic              wavA,
  output logic              wavB,
  output logic              ovrA,
  output logic              ovrB,
  output logic              irq
);
  dpCtl_t  ctl;
  dpStat_t stat;
  logic [CNT_W-1:0]  cfg;
  logic [FLAG_N-1:0] ien, flagsNow;
  logic [CH_N-1:0]   wav, ovr;
  logic [CNT_W-1:0]  cntNow, topNow;
  logic [2:0]        modeNow;
  logic              dirDown;

  timer8_datapath dp_i (
    .clk(clk), .rstN(rstN), .tick(cntEn),
    .cntWr(wrEn && wrAddr == ADDR_CNT),
    .cmpWr({wrEn && wrAddr == ADDR_CMPB, wrEn && wrAddr == ADDR_CMPA}),
    .wrData(wrData), .ctl(ctl), .stat(stat)
  );

  timer8_control ctrl_i (
    .clk(clk), .rstN(rstN), .tick(cntEn),
    .cfgWr(wrEn && wrAddr == ADDR_CFG),
    .ienWr(wrEn && wrAddr == ADDR_IEN),
    .flagWr(wrEn && wrAddr == ADDR_FLAG),
    .forceWr(wrEn && wrAddr == ADDR_FORCE),
    .wrData(wrData), .intAck(intAck), .stat(stat), .ctl(ctl),
    .cfg(cfg), .ien(ien), .flags(flagsNow), .wav(wav), .ovr(ovr), .irq(irq)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_CFG:  rdData = cfg;
      ADDR_CNT:  rdData = stat.cnt;
      ADDR_CMPA: rdData = stat.cmpA;
      ADDR_CMPB: rdData = stat.cmpB;
      ADDR_IEN:  rdData = {{(CNT_W-FLAG_N){1'b0}}, ien};
      ADDR_FLAG: rdData = {{(CNT_W-FLAG_N){1'b0}}, flagsNow};
      default:   rdData = '0;
    endcase
  end

  assign wavA    = wav[0];
  assign wavB    = wav[1];
  assign ovrA    = ovr[0];
  assign ovrB    = ovr[1];
  assign cntNow  = stat.cnt;
  assign dirDown = stat.down;
  assign modeNow = cfg[2:0];
  assign topNow  = ((modeNow == 3'd2) || (modeNow == 3'd5) || (modeNow == 3'd7)) ? stat.cmpA : CNT_MAX;
endmodule

// File: rtl/timer8_checker.sv
module timer8_checker
  import timer8_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cntEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [FLAG_N-1:0] wrLow,
  input logic [FLAG_N-1:0] intAck,
  input logic              irq,
  input logic [CNT_W-1:0]  cntNow,
  input logic [CNT_W-1:0]  topNow,
  input logic [2:0]        modeNow,
  input logic              dirDown,
  input logic [FLAG_N-1:0] flagsNow
);
  logic cntWrite;
  assign cntWrite = wrEn && (wrAddr == ADDR_CNT);

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 3'd0 && cntEn && !cntWrite) |=> (cntNow == CNT_W'($past(cntNow) + 1'b1))); // R2
  AST_FAST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((modeNow == 3'd3 || modeNow == 3'd7) && cntEn && !cntWrite && cntNow == topNow) |=> (cntNow == '0)); // R2
  AST_PHASE_OVF: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagsNow[FLG_OVF]) && $past(modeNow == 3'd1 || modeNow == 3'd5)) |-> ($past(cntNow) == '0 && $past(dirDown))); // R3
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_FORCE && !cntEn && intAck == '0) |=> $stable(flagsNow)); // R6
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_FLAG && wrLow == '1 && !cntEn) |=> !irq); // R11
endmodule

bind timer8_wavegen timer8_checker chk_i (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrLow(wrData[2:0]), .intAck(intAck), .irq(irq), .cntNow(cntNow),
  .topNow(topNow), .modeNow(modeNow), .dirDown(dirDown), .flagsNow(flagsNow)
);

// File: tb/timer8_wavegen_tb_top.sv
module timer8_wavegen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [2:0] intAck = '0;
  logic wavA, wavB, ovrA, ovrB, irq;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timer8_wavegen dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .intAck(intAck),
    .wavA(wavA), .wavB(wavB), .ovrA(ovrA), .ovrB(ovrB), .irq(irq)
  );

  // [7] channel, [6:4] mode, [3:2] action code, [1] pin after 1st force, [0] after 2nd
  localparam logic [7:0] VEC [8] = '{8'h06, 8'h08, 8'h2F, 8'h00, 8'h3C, 8'h14, 8'h86, 8'hAF};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    rdAddr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    rd("R1 cfg", 3'd0, 8'h00);
    rd("R1 cnt", 3'd1, 8'h00);
    rd("R1 flags", 3'd5, 8'h00);
    chk("R1 pins", {4'b0, wavA, wavB, ovrA, irq}, 8'h00);

    // vector table: force and action codes (R5 R6 R9 R12)
    for (int k = 0; k < 8; k++) begin
      logic ch;
      logic [7:0] cfgV;
      ch = VEC[k][7];
      wr(3'd0, 8'hA0);
      wr(3'd6, 8'h03);
      cfgV = ch ? {VEC[k][3:2], 3'b000, VEC[k][6:4]} : {2'b00, VEC[k][3:2], 1'b0, VEC[k][6:4]};
      wr(3'd0, cfgV);
      chk($sformatf("R12 override v%0d", k), {7'b0, ch ? ovrB : ovrA}, {7'b0, VEC[k][3:2] != 2'b00});
      wr(3'd6, ch ? 8'h02 : 8'h01);
      chk($sformatf("R5 force1 v%0d", k), {7'b0, ch ? wavB : wavA}, {7'b0, VEC[k][1]});
      wr(3'd6, ch ? 8'h02 : 8'h01);
      chk($sformatf("R5 force2 v%0d", k), {7'b0, ch ? wavB : wavA}, {7'b0, VEC[k][0]});
      rd("R6 no flag", 3'd5, 8'h00);
      rd("R6 no count", 3'd1, 8'h00);
    end

    // R3 R11 overflow in mode 0
    wr(3'd0, 8'h00); wr(3'd4, 8'h01); wr(3'd1, 8'hFD);
    ticks(2);
    rd("R2 count", 3'd1, 8'hFF);
    rd("R3 not yet", 3'd5, 8'h00);
    ticks(1);
    rd("R2 wrap", 3'd1, 8'h00);
    rd("R3 ovf", 3'd5, 8'h01);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    wr(3'd5, 8'h01);
    rd("R11 w1c", 3'd5, 8'h00);
    chk("R11 irq low", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'hFF); ticks(1);
    wr(3'd4, 8'h00);
    chk("R11 masked", {7'b0, irq}, 8'h00);
    rd("R11 still set", 3'd5, 8'h01);
    @(negedge clk); intAck = 3'b001; @(negedge clk); intAck = 3'b000; #1;
    rd("R11 ack", 3'd5, 8'h00);

    // R2 R4 R5 clear-on-compare
    wr(3'd5, 8'h07); wr(3'd0, 8'h12); wr(3'd2, 8'h03); wr(3'd1, 8'h00);
    ticks(3);
    rd("R2 ctc count", 3'd1, 8'h03);
    rd("R4 blocked at zero", 3'd5, 8'h00);
    chk("R5 no toggle yet", {7'b0, wavA}, 8'h00);
    ticks(1);
    rd("R2 ctc clear", 3'd1, 8'h00);
    rd("R4 match A", 3'd5, 8'h02);
    chk("R5 toggle", {7'b0, wavA}, 8'h01);

    // R4 counter write blocks next match
    wr(3'd0, 8'h10); wr(3'd5, 8'h07); wr(3'd2, 8'h05); wr(3'd1, 8'h05);
    ticks(1);
    rd("R4 suppressed", 3'd5, 8'h00);
    chk("R4 pin held", {7'b0, wavA}, 8'h01);
    wr(3'd1, 8'h04); ticks(2);
    rd("R4 later match", 3'd5, 8'h02);
    chk("R4 toggled", {7'b0, wavA}, 8'h00);

    // R7 R10 R3 single-slope, TOP from A
    wr(3'd5, 8'h07); wr(3'd0, 8'h00); wr(3'd2, 8'h04); wr(3'd3, 8'h02); wr(3'd1, 8'h00);
    wr(3'd0, 8'hC0); wr(3'd6, 8'h02);
    wr(3'd0, 8'h87);
    ticks(3);
    chk("R7 clear on match", {7'b0, wavB}, 8'h00);
    wr(3'd3, 8'h01);
    rd("R10 held", 3'd3, 8'h02);
    ticks(1);
    rd("R10 still held", 3'd3, 8'h02);
    ticks(1);
    rd("R10 loaded at bottom", 3'd3, 8'h01);
    rd("R3 ovf at top", 3'd5, 8'h07);
    rd("R2 fast wrap", 3'd1, 8'h00);
    chk("R7 set at top", {7'b0, wavB}, 8'h01);
    ticks(2);
    chk("R7 new compare", {7'b0, wavB}, 8'h00);

    // R7 compare equals TOP, mode 3
    wr(3'd0, 8'h20); wr(3'd6, 8'h01); wr(3'd2, 8'hFF); wr(3'd1, 8'hFD);
    wr(3'd0, 8'h23);
    ticks(3);
    chk("R7 top wins", {7'b0, wavA}, 8'h01);
    ticks(256);
    chk("R7 constant", {7'b0, wavA}, 8'h01);

    // R8 R10 R3 dual-slope, TOP from A
    wr(3'd5, 8'h07); wr(3'd0, 8'hC0); wr(3'd6, 8'h02);
    wr(3'd2, 8'h03); wr(3'd3, 8'h01); wr(3'd1, 8'h00);
    wr(3'd0, 8'h85);
    ticks(2);
    chk("R8 up clear", {7'b0, wavB}, 8'h00);
    rd("R2 up", 3'd1, 8'h02);
    wr(3'd3, 8'h02);
    rd("R10 phase held", 3'd3, 8'h01);
    ticks(2);
    rd("R10 loaded at top", 3'd3, 8'h02);
    rd("R2 turned down", 3'd1, 8'h02);
    ticks(1);
    chk("R8 down set", {7'b0, wavB}, 8'h01);
    rd("R2 down", 3'd1, 8'h01);
    ticks(1);
    rd("R3 no ovf yet", 3'd5, 8'h06);
    ticks(1);
    rd("R3 ovf at bottom", 3'd5, 8'h07);
    rd("R2 turned up", 3'd1, 8'h01);

    // R9 code 01 in a PWM mode
    wr(3'd0, 8'h55);
    ticks(2);
    chk("R9 B unchanged", {7'b0, wavB}, 8'h01);
    ticks(1);
    chk("R9 A toggles", {7'b0, wavA}, 8'h00);

    // R13 R6 readback
    wr(3'd4, 8'h05);
    rd("R13 ien", 3'd4, 8'h05);
    rd("R13 cfg", 3'd0, 8'h55);
    wr(3'd6, 8'h03);
    rd("R6 reads zero", 3'd6, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule